// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Programming Controller

This block sits behind the serial front end of a small byte-addressed non-volatile memory. When a write transaction opens, the front end presents the target address. Each data byte it assembles then enters through a valid/ready stream. The block stores the bytes in a page buffer that wraps within one page. It also records, one flag per byte, which page locations actually received data.

When chip select is released, the front end reports how many bits of the next byte were already shifted. The block commits the write only if that count is zero and at least one whole byte arrived. Any other release throws the transaction away.

A committed write starts a timed programming cycle. Write-in-progress is high for the whole cycle, which lasts a parameterised number of clock ticks. During the cycle, the flagged bytes are copied into the array through a second valid/ready stream. A single-cycle pulse, issued a configurable number of ticks before the end, tells the front end to clear its write-enable latch.

Top module: `wb_page_writer`

## Requirements
- R1: After reset, `wip`, `wel_clr`, `arr_valid` and `in_ready` are all 0.
- R2: `txn_start` opens a transaction (`in_ready` goes to 1 on the next cycle) only when `wel` is 1 in the same cycle and no cycle is in progress. Otherwise `in_ready` stays 0 and nothing reaches the array.
- R3: The first data byte goes to offset `start_addr[3:0]` of the page `start_addr[ADDR_W-1:4]`, and each further byte goes to the next offset. After offset 15 the next byte goes to offset 0 of the same page, and a later byte replaces an earlier one at the same offset.
- R4: A `desel` pulse with `bit_pos` equal to 0, after at least one accepted byte, starts the programming cycle: `wip` is 1 from the next cycle onward.
- R5: A `desel` pulse with `bit_pos` not equal to 0 cancels the transaction. `wip` stays 0 and the array receives no write.
- R6: A `desel` pulse with no accepted data byte starts no cycle and writes nothing.
- R7: When the array accepts every write at once, `wip` is high for exactly `PROG_CYCLES` consecutive cycles.
- R8: Each cycle raises `wel_clr` for exactly one clock while `wip` is high. When the array does not stall, `wip` stays high for exactly `WEL_LEAD` further cycles after that pulse.
- R9: During a cycle, the array receives exactly one write for each page offset that received a byte, carrying the last byte stored there. No other location is written, and no write occurs while `wip` is 0.
- R10: Array writes follow valid/ready. While `arr_valid` is 1 and `arr_ready` is 0, `arr_valid`, `arr_addr` and `arr_wdata` hold. If stalls delay the copy past the timed length, `wip` stays high until the last write is accepted.
- R11: While `wip` is 1, `in_ready` is 0. Incoming bytes, `txn_start` and `desel` are ignored and change no array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel | input | 1 | Current write-enable latch state |
| txn_start | input | 1 | One-cycle pulse: a write transaction begins |
| start_addr | input | ADDR_W | First byte address of the transaction |
| in_valid | input | 1 | A received data byte is offered |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` (high only while collecting) |
| in_data | input | DATA_W | Received data byte |
| bit_pos | input | $clog2(DATA_W) | Bits of the next byte already shifted in when `desel` fires (0 = byte boundary) |
| desel | input | 1 | One-cycle pulse: chip select released |
| wip | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| arr_valid | output | 1 | Array write offered |
| arr_ready | input | 1 | Array accepts the offered write |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench uses a 10-bit address, 16-byte pages, a 40-tick cycle and a 6-tick lead for the latch clear. With these values a full page, a wrap past offset 15 and a 20-byte overwrite all fit in a short run. A throttled array that takes one write in four stretches a 16-byte copy past the 40-tick cycle, which exercises the hold on `wip`. The small lead keeps the distance from the clear pulse to the fall of `wip` easy to count. A bench-side copy of the whole 1 KiB array shows that untouched locations keep their contents.

// File: rtl/wb_page_pkg.sv
package wb_page_pkg;
  typedef enum logic [1:0] {
    WB_IDLE    = 2'd0,
    WB_COLLECT = 2'd1,
    WB_PROG    = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wb_page_buf.sv
// Page-sized byte store with a wrapping write offset and per-entry fill flags.
module wb_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  load_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_BYTES-1:0] filled
);
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] ent [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_off <= '0;
    else if (load)   wr_off <= load_off;
    else if (wr_en)  wr_off <= wr_off + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && !load && (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) ent[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    filled[g] <= 1'b0;
      else if (load) filled[g] <= 1'b0;
      else if (hit)  filled[g] <= 1'b1;
    end
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/wb_copy_eng.sv
// Walks the page once, offering a write for every filled entry.
module wb_copy_eng #(
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PTR_W     = OFF_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  kick,
  input  logic [PAGE_BYTES-1:0] filled,
  input  logic                  take,
  output logic [OFF_W-1:0]      idx,
  output logic                  offer,
  output logic                  done
);
  localparam logic [PTR_W-1:0] END_PTR = PTR_W'(PAGE_BYTES);

  logic [PTR_W-1:0] ptr;

  assign done  = (ptr == END_PTR);
  assign idx   = ptr[OFF_W-1:0];
  assign offer = !done && filled[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr <= END_PTR;
    else if (kick)               ptr <= '0;
    else if (!done && (!filled[idx] || take))
                                 ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/wb_prog_timer.sv
// Tick counter for the programming cycle; flags the latch-clear point and the end.
module wb_prog_timer #(
  parameter int PROG_CYCLES = 200,
  parameter int WEL_LEAD    = 8,
  localparam int CNT_W      = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic run,
  output logic at_end,
  output logic clr_now
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CLR_AT = CNT_W'(PROG_CYCLES - 1 - WEL_LEAD);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (kick)                cnt <= '0;
    else if (run && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign at_end  = (cnt == LAST);
  assign clr_now = run && (cnt == CLR_AT);
endmodule

// File: rtl/wb_page_writer.sv
module wb_page_writer
  import wb_page_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 200,
  parameter int WEL_LEAD    = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int BIT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BIT_W-1:0]  bit_pos,
  input  logic              desel,
  output logic              wip,
  output logic              wel_clr,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  wb_state_e state, state_nx;
  logic [ADDR_W-OFF_W-1:0] page_q;
  logic [PAGE_BYTES-1:0]   filled;
  logic [OFF_W-1:0]        cp_idx;
  logic                    cp_done;
  logic                    open_txn, accept, commit, kick;
  logic                    t_end, t_clr;

  assign open_txn = (state == WB_IDLE) && txn_start && wel;
  assign accept   = (state == WB_COLLECT) && in_valid;
  assign commit   = (state == WB_COLLECT) && desel && (bit_pos == '0) &&
                    ((|filled) || in_valid);
  assign kick     = commit;

  always_comb begin
    state_nx = state;
    unique case (state)
      WB_IDLE:    if (open_txn) state_nx = WB_COLLECT;
      WB_COLLECT: if (desel)    state_nx = commit ? WB_PROG : WB_IDLE;
      WB_PROG:    if (t_end && cp_done) state_nx = WB_IDLE;
      default:    state_nx = WB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WB_IDLE;
      page_q <= '0;
    end else begin
      state <= state_nx;
      if (open_txn) page_q <= start_addr[ADDR_W-1:OFF_W];
    end
  end

  wb_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (open_txn),
    .load_off (start_addr[OFF_W-1:0]),
    .wr_en    (accept),
    .wr_data  (in_data),
    .rd_idx   (cp_idx),
    .rd_data  (arr_wdata),
    .filled   (filled)
  );

  wb_copy_eng #(.PAGE_BYTES(PAGE_BYTES)) u_copy (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .filled (filled),
    .take   (arr_ready),
    .idx    (cp_idx),
    .offer  (arr_valid),
    .done   (cp_done)
  );

  wb_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .WEL_LEAD(WEL_LEAD)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .run     (wip),
    .at_end  (t_end),
    .clr_now (t_clr)
  );

  assign wip      = (state == WB_PROG);
  assign in_ready = (state == WB_COLLECT);
  assign wel_clr  = t_clr;
  assign arr_addr = {page_q, cp_idx};
endmodule

// File: rtl/wb_page_writer_chk.sv
module wb_page_writer_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wel,
  input logic              txn_start,
  input logic              in_ready,
  input logic [BIT_W-1:0]  bit_pos,
  input logic              desel,
  input logic              wip,
  input logic              wel_clr,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_wdata
);
  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_wdata)); // R10
  AST_ARR_ONLY_IN_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> wip); // R9
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr); // R8
  AST_CLR_IN_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> wip); // R8
  AST_NO_READY_IN_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !in_ready); // R11
  AST_CANCEL_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && desel && (bit_pos != '0) |=> !wip); // R5
  AST_WIP_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(desel) && ($past(bit_pos) == '0)); // R4
  AST_OPEN_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(txn_start && wel)); // R2
endmodule

bind wb_page_writer wb_page_writer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BIT_W  (BIT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wel       (wel),
  .txn_start (txn_start),
  .in_ready  (in_ready),
  .bit_pos   (bit_pos),
  .desel     (desel),
  .wip       (wip),
  .wel_clr   (wel_clr),
  .arr_valid (arr_valid),
  .arr_ready (arr_ready),
  .arr_addr  (arr_addr),
  .arr_wdata (arr_wdata)
);

// File: tb/tb_wb_page_writer.sv
`timescale 1ns/1ps
module tb_wb_page_writer;
  localparam int AW = 10, DW = 8, PB = 16, PC = 40, LEAD = 6;
  localparam int MEMN = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wel = 0, txn_start = 0, in_valid = 0, desel = 0, arr_ready = 1;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [2:0] bit_pos = '0;
  logic in_ready, wip, wel_clr, arr_valid;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int checks = 0, fails = 0, cyc = 0, writes = 0, rc = 0;
  bit stall_mode = 0;
  logic [7:0] tb_mem [MEMN];
  logic [7:0] exp_mem [MEMN];

  always #10 clk = ~clk;

  wb_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB),
                   .PROG_CYCLES(PC), .WEL_LEAD(LEAD)) dut (
    .clk(clk), .rst_n(rst_n), .wel(wel), .txn_start(txn_start),
    .start_addr(start_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bit_pos(bit_pos), .desel(desel), .wip(wip),
    .wel_clr(wel_clr), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  // array model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_valid && arr_ready) begin
      tb_mem[arr_addr] <= arr_wdata;
      writes <= writes + 1;
    end
  end

  always @(negedge clk) begin
    rc = rc + 1;
    arr_ready = stall_mode ? ((rc % 4) == 3) : 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  typedef struct packed {
    logic [9:0] addr;
    logic [5:0] n;
    logic [7:0] seed;
    logic [2:0] bp;
    logic       wl;
    logic       stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{10'h005, 6'd1,  8'h11, 3'd0, 1'b1, 1'b0},  // single byte
    '{10'h120, 6'd16, 8'h40, 3'd0, 1'b1, 1'b0},  // full page
    '{10'h2FC, 6'd6,  8'h80, 3'd0, 1'b1, 1'b0},  // wraps past offset 15
    '{10'h033, 6'd20, 8'h21, 3'd0, 1'b1, 1'b0},  // overwrite after wrap
    '{10'h050, 6'd3,  8'h55, 3'd3, 1'b1, 1'b0},  // off-boundary cancel
    '{10'h060, 6'd0,  8'h66, 3'd0, 1'b1, 1'b0},  // no data bytes
    '{10'h070, 6'd4,  8'h77, 3'd0, 1'b0, 1'b0},  // latch not set
    '{10'h3F0, 6'd16, 8'h91, 3'd0, 1'b1, 1'b1},  // stalled array
    '{10'h1FF, 6'd2,  8'hA5, 3'd0, 1'b1, 1'b0}   // start at last offset
  };

  task automatic mem_compare(input string req);
    int bad = 0;
    for (int a = 0; a < MEMN; a++) if (tb_mem[a] !== exp_mem[a]) bad++;
    chk(req, bad, 0, "array mismatching bytes");
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    bit commit;
    int uniq, hi, clr_n, after;
    bit seen;
    commit = v.wl && (v.bp == 0) && (v.n != 0);
    uniq = (v.n > PB) ? PB : int'(v.n);
    writes = 0;
    stall_mode = v.stall;
    wel = v.wl; txn_start = 1; start_addr = v.addr;
    @(negedge clk);
    txn_start = 0; wel = 0;
    chk("R2", in_ready, v.wl, $sformatf("vec%0d in_ready after open", vi));
    for (int k = 0; k < v.n; k++) begin
      in_valid = 1; in_data = v.seed + 8'(k * 7);
      @(negedge clk);
    end
    in_valid = 0;
    desel = 1; bit_pos = v.bp;
    @(negedge clk);
    desel = 0; bit_pos = 0;
    if (v.bp != 0)      chk("R5", wip, 0, $sformatf("vec%0d wip after cancel", vi));
    else if (v.n == 0)  chk("R6", wip, 0, $sformatf("vec%0d wip with no bytes", vi));
    else                chk("R4", wip, commit, $sformatf("vec%0d wip after deselect", vi));
    if (commit)
      for (int k = 0; k < v.n; k++)
        exp_mem[{v.addr[9:4], 4'(v.addr[3:0] + k)}] = v.seed + 8'(k * 7);
    hi = 0; clr_n = 0; after = 0; seen = 0;
    while (wip && hi < 500) begin
      hi++;
      if (wel_clr) begin clr_n++; seen = 1; end
      else if (seen) after++;
      @(negedge clk);
    end
    if (commit) begin
      chk("R8", clr_n, 1, $sformatf("vec%0d latch-clear pulses", vi));
      if (!v.stall) begin
        chk("R7", hi, PC, $sformatf("vec%0d wip length", vi));
        chk("R8", after, LEAD, $sformatf("vec%0d wip cycles after clear", vi));
      end else begin
        chk("R10", int'(hi > PC), 1, $sformatf("vec%0d wip stretched by stalls", vi));
      end
    end else begin
      repeat (3) @(negedge clk);
      chk("R2", wip, 0, $sformatf("vec%0d no cycle", vi));
    end
    chk("R9", writes, commit ? uniq : 0, $sformatf("vec%0d array write count", vi));
    mem_compare(v.n > PB ? "R3" : "R9");
    stall_mode = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < MEMN; a++) begin tb_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", wip, 0, "wip after reset");
    chk("R1", wel_clr, 0, "wel_clr after reset");
    chk("R1", arr_valid, 0, "arr_valid after reset");
    chk("R1", in_ready, 0, "in_ready after reset");

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R11: activity during a cycle is ignored
    begin
      int wbefore, hi;
      writes = 0;
      wel = 1; txn_start = 1; start_addr = 10'h200;
      @(negedge clk); txn_start = 0;
      in_valid = 1; in_data = 8'hC3; @(negedge clk); in_valid = 0;
      desel = 1; @(negedge clk); desel = 0;
      exp_mem[10'h200] = 8'hC3;
      chk("R11", wip, 1, "cycle running for busy test");
      txn_start = 1; start_addr = 10'h300; @(negedge clk); txn_start = 0;
      chk("R11", in_ready, 0, "in_ready during cycle");
      for (int k = 0; k < 4; k++) begin
        in_valid = 1; in_data = 8'hE0 + 8'(k); @(negedge clk);
      end
      in_valid = 0;
      desel = 1; @(negedge clk); desel = 0; wel = 0;
      hi = 0;
      while (wip && hi < 500) begin hi++; @(negedge clk); end
      repeat (4) @(negedge clk);
      chk("R11", wip, 0, "no second cycle from ignored transaction");
      chk("R11", in_ready, 0, "start during cycle not held over");
      wbefore = writes;
      chk("R11", wbefore, 1, "only committed byte written");
      mem_compare("R11");
    end
    finish_run();
  end
endmodule